// File: doc/BRIEF.md
# Fall-Through Handshake FIFO Register

This block is a first-in first-out store of 64 words, each 9 bits wide, built as a chain of stages rather than as an addressed memory. A word accepted at the input stage moves forward one stage per clock toward the output. It keeps moving until it reaches the output stage or stops behind an occupied stage. When a word leaves the output stage, the empty slot it leaves behind travels back toward the input in the same way, one stage per clock.

A producer sees a ready flag on the input side and pulses a shift-in strobe to hand over a word. A consumer sees a ready flag on the output side and pulses a shift-out strobe to take the word away. Both strobes are sampled on a single system clock and act on their rising edge. The shift-out strobe also acts on its falling edge. An active-low master reset empties the whole chain. The data output is three-state, under an output-enable input.

Top module: `ft_fifo_register`

## Requirements
- R1: While `rstN` is low, and after it is released, every stage is empty, `inReady` is 1 and `outReady` is 0, whatever the store held before.
- R2: The clock edge that first samples `shiftIn` at 1 after sampling it at 0 captures `dataIn` if `inReady` is 1. `inReady` is then 0 after that edge. It is 1 again after the next edge if the second stage was free.
- R3: A shift-in edge while `inReady` is 0 is ignored: no word is added and the stored words are unchanged.
- R4: A word captured into an empty store reaches the output stage 63 clock edges after its capture edge. `outReady` turns 1 after that edge and not before.
- R5: Words leave in the order they were captured, with no loss, duplication or change of value.
- R6: A shift-out rising edge sampled while `outReady` is 1 makes `outReady` 0 after that same edge. The output word is held while the stage is busy.
- R7: The edge that samples `shiftOut` back at 0 during a busy period empties the output stage. If the stage behind it holds a word, that word moves in on the following edge, and `outReady` is 1 after it.
- R8: A shift-out pulse while `outReady` is 0 is ignored and removes no word.
- R9: All 64 stages can be filled. While they are, `inReady` stays 0.
- R10: With `outEnable` at 1, `dataOut` carries the output-stage word unchanged. With `outEnable` at 0, `dataOut` is high-impedance.
- R11: After the last stored word has been shifted out, `outReady` stays 0 until a new word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous master reset |
| shiftIn | input | 1 | Shift-in strobe; acts on its rising edge |
| dataIn | input | 9 | Word to store |
| inReady | output | 1 | Input stage free; a word can be accepted |
| shiftOut | input | 1 | Shift-out strobe; rise marks busy, fall unloads |
| outReady | output | 1 | Valid word waiting in the output stage |
| outEnable | input | 1 | Drives `dataOut` when 1; high-impedance when 0 |
| dataOut | output | 9 | Output-stage word, three-state |

## Verification
A captured word drops `inReady` one edge after capture. In an empty store it raises `outReady` 63 edges after capture. A shift-out rise drops `outReady` one edge later. The shift-out fall empties the output stage on its edge, and the next word is ready one edge after that. Inputs are driven on the falling clock edge and outputs are sampled a few nanoseconds after each rising edge, so the bench counts edges from the capturing or unloading edge and checks the flags exactly in the cycle each one is due. A queue model in the bench holds the expected words. Every cycle it is compared with the flags and the output word: an empty queue needs `outReady` at 0, a full one needs `inReady` at 0, and a ready output must match the oldest queued word.

// File: rtl/ftfifo_pkg.sv
package ftfifo_pkg;

  // Strobes from the handshake control to the stage chain.
  typedef struct packed {
    logic write;   // load dataIn into the input stage
    logic unload;  // empty the output stage
  } ctrlStrobe_t;

endpackage

// File: rtl/ft_stage_chain.sv
module ft_stage_chain
  import ftfifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [WIDTH-1:0] dataIn,
  output logic             headFull,
  output logic             tailValid,
  output logic [WIDTH-1:0] tailWord
);

  localparam int LASTIDX = DEPTH - 1;

  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] move;
  logic [DEPTH-1:0] fill;
  logic [DEPTH-1:0] drain;
  logic [WIDTH-1:0] dataQ    [DEPTH];
  logic [WIDTH-1:0] fillData [DEPTH];

  // A stage hands its word forward whenever the next stage is empty.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == LASTIDX) begin : g_tail
        assign move[i]  = 1'b0;
        assign drain[i] = ctrl.unload;
      end else begin : g_body
        assign move[i]  = validQ[i] & ~validQ[i+1];
        assign drain[i] = move[i];
      end
      if (i == 0) begin : g_head
        assign fill[i]     = ctrl.write;
        assign fillData[i] = dataIn;
      end else begin : g_link
        assign fill[i]     = move[i-1];
        assign fillData[i] = dataQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < DEPTH; i++) dataQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        validQ[i] <= (validQ[i] & ~drain[i]) | fill[i];
        if (fill[i]) dataQ[i] <= fillData[i];
      end
    end
  end

  assign headFull  = validQ[0];
  assign tailValid = validQ[LASTIDX];
  assign tailWord  = dataQ[LASTIDX];

  // A write strobe only ever lands in a free input stage.
  p_write_into_free_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.write |-> !validQ[0]);

  // The captured word is in the input stage one edge later.
  p_capture_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.write |=> (validQ[0] && dataQ[0] == $past(dataIn)));

  // An unload only happens on a populated output stage.
  p_unload_populated_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.unload |-> validQ[LASTIDX]);

  // Output word is frozen until it is unloaded.
  p_tail_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validQ[LASTIDX] && !ctrl.unload) |=> (validQ[LASTIDX] && $stable(dataQ[LASTIDX])));

  // A completely full chain stays full until something leaves.
  p_full_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    (&validQ && !ctrl.unload) |=> &validQ);

endmodule

// File: rtl/ft_handshake_ctrl.sv
module ft_handshake_ctrl
  import ftfifo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftIn,
  input  logic        shiftOut,
  input  logic        headFull,
  input  logic        tailValid,
  output ctrlStrobe_t ctrl,
  output logic        inReady,
  output logic        outReady
);

  logic siQ;
  logic soQ;
  logic busyQ;
  logic siRise;
  logic soRise;
  logic soFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siQ   <= 1'b0;
      soQ   <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      siQ <= shiftIn;
      soQ <= shiftOut;
      if (soRise && outReady) busyQ <= 1'b1;
      else if (soFall)        busyQ <= 1'b0;
    end
  end

  assign siRise = shiftIn & ~siQ;
  assign soRise = shiftOut & ~soQ;
  assign soFall = ~shiftOut & soQ;

  assign inReady  = ~headFull;
  assign outReady = tailValid & ~busyQ;

  always_comb begin
    ctrl        = '0;
    ctrl.write  = siRise & inReady;
    ctrl.unload = soFall & busyQ;
  end

  // Output flag drops on the edge that sees the shift-out rise.
  p_busy_on_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    (soRise && outReady) |=> !outReady);

  // A shift-out rise with nothing waiting starts no busy period.
  p_ignore_empty_so_r8: assert property (@(posedge clk) disable iff (!rstN)
    (soRise && !tailValid) |=> !busyQ);

endmodule

// File: rtl/ft_fifo_register.sv
module ft_fifo_register
  import ftfifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic             outReady,
  input  logic             outEnable,
  output logic [WIDTH-1:0] dataOut
);

  ctrlStrobe_t      ctrl;
  logic             headFull;
  logic             tailValid;
  logic [WIDTH-1:0] tailWord;

  ft_handshake_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .headFull (headFull),
    .tailValid(tailValid),
    .ctrl     (ctrl),
    .inReady  (inReady),
    .outReady (outReady)
  );

  ft_stage_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dataIn   (dataIn),
    .headFull (headFull),
    .tailValid(tailValid),
    .tailWord (tailWord)
  );

  assign dataOut = outEnable ? tailWord : {WIDTH{1'bz}};

endmodule

// File: tb/ft_fifo_register_tb.sv
module ft_fifo_register_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftIn = 1'b0;
  logic       shiftOut = 1'b0;
  logic       outEnable = 1'b1;
  logic [8:0] dataIn = '0;
  logic       inReady;
  logic       outReady;
  wire  [8:0] dataOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [8:0] q[$];

  always #5 clk = ~clk;

  ft_fifo_register u_dut (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .outReady(outReady),
    .outEnable(outEnable), .dataOut(dataOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model compared every cycle, shortly after the rising edge.
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    #3;
    if (q.size() == 0) check(outReady == 1'b0, "R11 empty model needs outReady 0", outReady, 0);
    if (q.size() == 64) check(inReady == 1'b0, "R9 full model needs inReady 0", inReady, 0);
    if (outReady && outEnable && q.size() > 0)
      check(dataOut === q[0], "R5 output word order", dataOut, q[0]);
  end

  task automatic writeWord(input logic [8:0] w);
    while (!inReady) @(negedge clk);
    dataIn  = w;
    shiftIn = 1'b1;
    @(negedge clk);
    q.push_back(w);
    shiftIn = 1'b0;
  endtask

  task automatic readWord(input bit detail);
    while (!outReady) @(negedge clk);
    check(dataOut === q[0], "R5 word before shift-out", dataOut, q[0]);
    shiftOut = 1'b1;
    @(negedge clk);
    check(outReady == 1'b0, "R6 busy after shift-out rise", outReady, 0);
    check(dataOut === q[0], "R6 word held while busy", dataOut, q[0]);
    shiftOut = 1'b0;
    void'(q.pop_front());
    @(negedge clk);
    if (detail) check(outReady == 1'b0, "R7 stage empty after unload edge", outReady, 0);
    @(negedge clk);
    if (detail) begin
      check(outReady == 1'b1, "R7 next word ready one edge later", outReady, 1);
      check(dataOut === q[0], "R7 next word value", dataOut, q[0]);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    q.delete();
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady during reset", inReady, 1);
    check(outReady == 1'b0, "R1 outReady during reset", outReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    check(outReady == 1'b0, "R1 outReady after reset", outReady, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);
    check(outReady == 1'b0, "R1 reset outReady", outReady, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: shift-out pulse on an empty store does nothing
    shiftOut = 1'b1;
    @(negedge clk);
    shiftOut = 1'b0;
    repeat (3) @(negedge clk);
    check(outReady == 1'b0, "R8 empty shift-out ignored", outReady, 0);

    // R2 / R4: capture and fall-through latency
    dataIn  = 9'h1A5;
    shiftIn = 1'b1;
    @(negedge clk);            // one edge after capture
    q.push_back(9'h1A5);
    shiftIn = 1'b0;
    check(inReady == 1'b0, "R2 inReady drops after capture", inReady, 0);
    @(negedge clk);            // two edges after capture
    check(inReady == 1'b1, "R2 inReady back after move", inReady, 1);
    repeat (61) @(negedge clk); // 63rd negedge: 62 edges after capture
    check(outReady == 1'b0, "R4 not ready before 63 edges", outReady, 0);
    @(negedge clk);
    check(outReady == 1'b1, "R4 ready 63 edges after capture", outReady, 1);
    check(dataOut === 9'h1A5, "R4 fall-through word", dataOut, 9'h1A5);
    readWord(1'b0);
    repeat (70) @(negedge clk);
    check(outReady == 1'b0, "R11 stays empty after last read", outReady, 0);

    // R10: three-state output
    writeWord(9'h0C3);
    while (!outReady) @(negedge clk);
    outEnable = 1'b0;
    @(negedge clk);
    check(dataOut === 9'bz, "R10 high-impedance when disabled", dataOut, 0);
    outEnable = 1'b1;
    @(negedge clk);
    check(dataOut === 9'h0C3, "R10 driven non-inverted", dataOut, 9'h0C3);
    readWord(1'b0);

    // R9 / R3: fill all 64, then try one more
    for (int i = 0; i < 64; i++) writeWord(9'((i * 37) ^ 9'h155));
    repeat (70) @(negedge clk);
    check(inReady == 1'b0, "R9 inReady low when full", inReady, 0);
    check(outReady == 1'b1, "R9 output ready when full", outReady, 1);
    dataIn  = 9'h0FF;
    shiftIn = 1'b1;
    @(negedge clk);
    shiftIn = 1'b0;
    repeat (10) @(negedge clk);
    check(inReady == 1'b0, "R3 shift-in while full ignored", inReady, 0);
    readWord(1'b1);
    for (int i = 1; i < 64; i++) readWord(1'b0);
    repeat (80) @(negedge clk);
    check(outReady == 1'b0, "R11 empty after draining 64", outReady, 0);
    check(inReady == 1'b1, "R9 input free after draining", inReady, 1);

    // R1: master reset with words stored
    for (int i = 0; i < 20; i++) writeWord(9'(i + 9'h40));
    repeat (70) @(negedge clk);
    doReset();
    repeat (70) @(negedge clk);
    check(outReady == 1'b0, "R1 no word survives reset", outReady, 0);

    // R5: interleaved traffic
    for (int i = 0; i < 5; i++) writeWord(9'(9'h100 + i));
    readWord(1'b0);
    readWord(1'b0);
    for (int i = 0; i < 3; i++) writeWord(9'(9'h0A0 + i));
    for (int i = 0; i < 6; i++) readWord(1'b0);
    repeat (70) @(negedge clk);
    check(outReady == 1'b0, "R5 all interleaved words consumed", outReady, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule